// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a master-side sequencer. It waits for a serial EEPROM to finish its internal programming cycle, and it is started only after a write has been issued to that device. The poller sends a START followed by the device select byte with the RW bit cleared. It then reads the acknowledge bit. A missing acknowledge means the device is still busy, so the poller opens a new attempt. An acknowledge means the device is free and has already taken that select byte as the first byte of the next instruction. The poller therefore never sends that byte again.

After the acknowledge, what happens depends on the latched operation kind:
- If the next instruction does not touch the memory array, the poller ends the transaction with STOP.
- Otherwise it sends the byte address and reads its acknowledge bit.
- For a write, it then hands the bus back with no STOP, so the data phase can continue.
- For a random read, it first issues a repeated START.

Every bus action is requested from a separate bit-level engine, one command at a time. The request is held until the engine returns a one-cycle done.

The poller stops trying after a programmable number of attempts. It then raises a timeout flag and releases the bus with STOP.

The state machine has eight states:
- IDLE
- POLL_START (START requested)
- POLL_DEV (select byte requested)
- POLL_ACK (acknowledge read)
- ADDR_SEND (byte address requested)
- ADDR_ACK (address acknowledge read)
- RESTART (repeated START requested)
- STOP (STOP requested)

Its transitions are:
- IDLE→POLL_START on `go`.
- POLL_START→POLL_DEV→POLL_ACK on engine done.
- POLL_ACK→POLL_START on NACK below the limit.
- POLL_ACK→STOP on NACK at the limit.
- POLL_ACK→STOP on ACK with kind "none".
- POLL_ACK→ADDR_SEND on ACK with a memory kind.
- ADDR_SEND→ADDR_ACK on engine done.
- ADDR_ACK→RESTART for reads, or →IDLE for writes.
- RESTART→IDLE and STOP→IDLE on engine done.

Top module: `ack_poller`

## Requirements
- R1: After reset, `busy`, `eng_req`, `ready`, `done` and `timeout` are 0 and `tries` is 0; while `busy` is 0, `eng_req` is 0.
- R2: Each attempt requests, in order, START (`eng_op`=0), SEND (`eng_op`=1) with `eng_byte` = {`dev_sel`,1'b0}, and ACK-read (`eng_op`=2). `eng_req`, `eng_op` and `eng_byte` hold steady until `eng_done` is seen.
- R3: An ACK-read completed with `eng_ack`=0 below the limit starts a new attempt with START, and `tries` rises by exactly one per attempt.
- R4: An ACK-read of the select byte completed with `eng_ack`=1 gives a one-cycle `ready` pulse in the next cycle, and the select byte is not sent again.
- R5: With `op_kind`=0 (no memory access), the command after the acknowledged poll is STOP (`eng_op`=4).
- R6: With `op_kind`=1 (write), the commands after the acknowledge are SEND of `mem_addr` and then ACK-read, with no STOP.
- R7: With `op_kind`=2 or 3 (random read), the commands after the acknowledge are SEND of `mem_addr`, ACK-read, and then RESTART (`eng_op`=3).
- R8: When `max_tries` attempts have all been refused, `timeout` goes to 1, STOP follows, and no `ready` pulse appears. A `max_tries` of 0 allows one attempt.
- R9: After `done`, `tries` holds the number of attempts used and `timeout` holds its value; the next accepted `go` clears both.
- R10: `done` is a one-cycle pulse in the cycle after the final command's `eng_done`, and `busy` falls in that same cycle.
- R11: `go`, and any change of `op_kind`, `mem_addr` or `max_tries`, has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start polling; accepted only when idle |
| op_kind | input | 2 | Next instruction: 0 none, 1 write, 2/3 random read |
| dev_sel | input | 7 | Device select address bits |
| mem_addr | input | 8 | Byte address for memory operations |
| max_tries | input | TRY_W | Attempt limit (0 treated as 1) |
| eng_req | output | 1 | Command request to the bit engine |
| eng_op | output | 3 | Command: 0 START, 1 SEND, 2 ACK-read, 3 RESTART, 4 STOP |
| eng_byte | output | 8 | Byte for SEND commands |
| eng_done | input | 1 | Engine has completed the requested command |
| eng_ack | input | 1 | Acknowledge bit read by an ACK-read command |
| busy | output | 1 | Transaction in progress |
| ready | output | 1 | One-cycle pulse when the device acknowledges |
| done | output | 1 | One-cycle pulse at the end of the transaction |
| timeout | output | 1 | Attempt limit was reached without acknowledge |
| tries | output | TRY_W | Number of attempts used |

## Verification
The bound checker covers several rules on every cycle:
- a request stays stable until the engine answers;
- no request is made while idle;
- `tries` only grows by one during a transaction and starts from zero;
- `ready` follows only an acknowledged ACK-read and never appears with `timeout`;
- `done` is a single-cycle pulse taken with `busy` low.

Other behaviour is visible only through the bench scenarios:
- the exact command order for each operation kind;
- the byte contents;
- the attempt count at the limit boundary and at a limit of zero;
- the clearing of `timeout` by the next start;
- the ignoring of inputs during a run.

// File: rtl/ap_pkg.sv
package ap_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_START,
        S_POLL_DEV,
        S_POLL_ACK,
        S_ADDR_SEND,
        S_ADDR_ACK,
        S_RESTART,
        S_STOP
    } ap_state_e;

    localparam logic [2:0] OP_START   = 3'd0;
    localparam logic [2:0] OP_SEND    = 3'd1;
    localparam logic [2:0] OP_RDACK   = 3'd2;
    localparam logic [2:0] OP_RESTART = 3'd3;
    localparam logic [2:0] OP_STOP    = 3'd4;

    localparam logic [1:0] KIND_NONE  = 2'd0;
endpackage

// File: rtl/ap_try_counter.sv
module ap_try_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_limit
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + W'(1);
    end

    always_comb begin
        lim_eff  = (limit == '0) ? W'(1) : limit;
        at_limit = (cnt_q >= lim_eff);
    end

    assign count = cnt_q;
endmodule

// File: rtl/ap_cmd_map.sv
module ap_cmd_map
    import ap_pkg::*;
(
    input  ap_state_e          st,
    input  logic [DEV_W-1:0]   dev,
    input  logic [BYTE_W-1:0]  maddr,
    output logic               req,
    output logic [2:0]         op,
    output logic [BYTE_W-1:0]  data
);
    always_comb begin
        req  = 1'b1;
        op   = OP_STOP;
        data = '0;
        unique case (st)
            S_IDLE:       req = 1'b0;
            S_POLL_START: op  = OP_START;
            S_POLL_DEV: begin
                op   = OP_SEND;
                data = {dev, 1'b0};
            end
            S_POLL_ACK:   op  = OP_RDACK;
            S_ADDR_SEND: begin
                op   = OP_SEND;
                data = maddr;
            end
            S_ADDR_ACK:   op  = OP_RDACK;
            S_RESTART:    op  = OP_RESTART;
            S_STOP:       op  = OP_STOP;
            default:      req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ack_poller.sv
module ack_poller
    import ap_pkg::*;
#(
    parameter int TRY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [1:0]       op_kind,
    input  logic [6:0]       dev_sel,
    input  logic [7:0]       mem_addr,
    input  logic [TRY_W-1:0] max_tries,
    output logic             eng_req,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_byte,
    input  logic             eng_done,
    input  logic             eng_ack,
    output logic             busy,
    output logic             ready,
    output logic             done,
    output logic             timeout,
    output logic [TRY_W-1:0] tries
);
    ap_state_e          state, nxt;
    logic [1:0]         kind_q;
    logic [DEV_W-1:0]   dev_q;
    logic [BYTE_W-1:0]  addr_q;
    logic [TRY_W-1:0]   lim_q;
    logic               step, accept, at_limit, finish;

    assign accept = (state == S_IDLE) && go;
    assign step   = eng_req && eng_done;
    assign finish = step && (nxt == S_IDLE);
    assign busy   = (state != S_IDLE);

    ap_cmd_map u_map (
        .st    (state),
        .dev   (dev_q),
        .maddr (addr_q),
        .req   (eng_req),
        .op    (eng_op),
        .data  (eng_byte)
    );

    ap_try_counter #(.W(TRY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .inc      (step && state == S_POLL_START),
        .limit    (lim_q),
        .count    (tries),
        .at_limit (at_limit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (go) nxt = S_POLL_START;
            S_POLL_START: if (step) nxt = S_POLL_DEV;
            S_POLL_DEV:   if (step) nxt = S_POLL_ACK;
            S_POLL_ACK: if (step) begin
                if (eng_ack)       nxt = (kind_q == KIND_NONE) ? S_STOP : S_ADDR_SEND;
                else if (at_limit) nxt = S_STOP;
                else               nxt = S_POLL_START;
            end
            S_ADDR_SEND:  if (step) nxt = S_ADDR_ACK;
            S_ADDR_ACK:   if (step) nxt = kind_q[1] ? S_RESTART : S_IDLE;
            S_RESTART:    if (step) nxt = S_IDLE;
            S_STOP:       if (step) nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready   <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
            kind_q  <= '0;
            dev_q   <= '0;
            addr_q  <= '0;
            lim_q   <= '0;
        end else begin
            ready <= step && (state == S_POLL_ACK) && eng_ack;
            done  <= finish;
            if (accept) begin
                timeout <= 1'b0;
                kind_q  <= op_kind;
                dev_q   <= dev_sel;
                addr_q  <= mem_addr;
                lim_q   <= max_tries;
            end else if (step && state == S_POLL_ACK && !eng_ack && at_limit) begin
                timeout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ap_chk.sv
module ap_chk #(
    parameter int TRY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_req,
    input logic [2:0]       eng_op,
    input logic [7:0]       eng_byte,
    input logic             eng_done,
    input logic             eng_ack,
    input logic             busy,
    input logic             ready,
    input logic             done,
    input logic             timeout,
    input logic [TRY_W-1:0] tries
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

    // R3
    tries_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (tries == $past(tries) || tries == $past(tries) + TRY_W'(1)));

    // R4
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(eng_req && eng_done && eng_ack && eng_op == 3'd2));

    // R8
    ready_vs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !ready);

    // R9
    tries_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tries == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind ack_poller ap_chk #(.TRY_W(TRY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_req  (eng_req),
    .eng_op   (eng_op),
    .eng_byte (eng_byte),
    .eng_done (eng_done),
    .eng_ack  (eng_ack),
    .busy     (busy),
    .ready    (ready),
    .done     (done),
    .timeout  (timeout),
    .tries    (tries)
);

// File: tb/sim_ack_poller.sv
`timescale 1ns/1ps
module sim_ack_poller;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic [6:0]    dev_sel = 7'h50;
    logic [7:0]    mem_addr = 8'h00;
    logic [TW-1:0] max_tries = '0;
    logic          eng_req;
    logic [2:0]    eng_op;
    logic [7:0]    eng_byte;
    logic          eng_done = 1'b0;
    logic          eng_ack = 1'b0;
    logic          busy, ready, done, timeout;
    logic [TW-1:0] tries;

    always #2 clk = ~clk;

    ack_poller #(.TRY_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .op_kind(op_kind), .dev_sel(dev_sel),
        .mem_addr(mem_addr), .max_tries(max_tries), .eng_req(eng_req), .eng_op(eng_op),
        .eng_byte(eng_byte), .eng_done(eng_done), .eng_ack(eng_ack), .busy(busy),
        .ready(ready), .done(done), .timeout(timeout), .tries(tries)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];          // op*512 + byte; byte 256 = poll ack-read, 257 = address ack-read
    int busy_polls = 0;
    int poll_seen = 0;
    int lat = 1;
    int wait_cnt = 0;
    bit exp_busy = 0, exp_ready = 0, exp_done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model + engine responder, evaluated once per clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit nb, nr, nd;
            chk(busy == exp_busy, "R10 busy", busy, exp_busy);
            chk(ready == exp_ready, "R4 ready pulse", ready, exp_ready);
            chk(done == exp_done, "R10 done pulse", done, exp_done);
            nr = 0;
            nd = 0;
            nb = exp_busy | go;
            if (eng_done) begin
                eng_done = 1'b0;
                eng_ack  = 1'b0;
                wait_cnt = 0;
            end else if (eng_req) begin
                wait_cnt++;
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 unexpected command", int'(eng_op), -1);
                    end else begin
                        int e, eo, eb;
                        e  = exp_q.pop_front();
                        eo = e / 512;
                        eb = e % 512;
                        chk(int'(eng_op) == eo, "R2 command order", int'(eng_op), eo);
                        if (eo == 1) chk(int'(eng_byte) == eb, "R2 send byte", int'(eng_byte), eb);
                        eng_ack = 1'b1;
                        if (eb == 256) begin
                            eng_ack = (poll_seen >= busy_polls);
                            poll_seen++;
                            nr = eng_ack;
                        end
                        if (exp_q.size() == 0) begin
                            nd = 1;
                            nb = 0;
                        end
                    end
                    eng_done = 1'b1;
                end
            end
            exp_busy  = nb;
            exp_ready = nr;
            exp_done  = nd;
        end
    end

    task automatic run(int kind, int bp, int mx, int l, int addr, bit poke, string tag);
        int lim   = (mx == 0) ? 1 : mx;
        int att   = (bp + 1 < lim) ? bp + 1 : lim;
        bit acked = (bp < lim);
        int guard = 0;
        busy_polls = bp;
        poll_seen  = 0;
        lat        = l;
        op_kind    = 2'(kind);
        max_tries  = TW'(mx);
        mem_addr   = 8'(addr);
        for (int i = 0; i < att; i++) begin
            exp_q.push_back(0);
            exp_q.push_back(512 + int'({dev_sel, 1'b0}));
            exp_q.push_back(2 * 512 + 256);
        end
        if (!acked || kind == 0) begin
            exp_q.push_back(4 * 512);
        end else begin
            exp_q.push_back(512 + addr);
            exp_q.push_back(2 * 512 + 257);
            if (kind >= 2) exp_q.push_back(3 * 512);
        end
        @(posedge clk); #1 go = 1'b1;
        @(posedge clk); #1 go = 1'b0;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1 go = 1'b1; op_kind = 2'd2; mem_addr = 8'hEE; max_tries = TW'(1);
            @(posedge clk); #1 go = 1'b0;
        end
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        chk(int'(tries) == att, {tag, " R9 R3 tries"}, int'(tries), att);
        chk(timeout == !acked, {tag, " R8 timeout"}, timeout, !acked);
        chk(exp_q.size() == 0, {tag, " R2 all commands issued"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(posedge clk);
        chk(int'(tries) == att && timeout == !acked, {tag, " R9 held after done"}, int'(tries), att);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !eng_req && !ready && !done && !timeout && tries == '0,
            "R1 reset state", {busy, eng_req, ready, done, timeout}, 0);
        run(1, 0, 5, 1, 8'h3C, 0, "write immediate R6");
        run(1, 3, 5, 2, 8'hA5, 0, "write after busy R3 R6");
        run(2, 2, 6, 1, 8'h11, 0, "random read R7");
        run(3, 0, 2, 3, 8'h77, 0, "kind3 read R7");
        run(0, 1, 4, 1, 8'h00, 0, "no memory access R5");
        run(1, 10, 4, 1, 8'h20, 0, "never acks R8");
        run(1, 3, 4, 2, 8'h21, 0, "ack on last attempt R8 R4");
        run(0, 0, 0, 1, 8'h00, 0, "limit zero ack R8");
        run(1, 1, 0, 1, 8'h22, 0, "limit zero timeout R8");
        run(1, 0, 3, 1, 8'h55, 0, "timeout cleared R9");
        run(1, 3, 8, 1, 8'h66, 1, "go ignored while busy R11");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule